// File: doc/BRIEF.md
# Room Occupancy Counter

This block tracks how many people are inside a room that has a single way in and a single way out. Each doorway carries a light-beam sensor whose output is high while the beam is unbroken and low while someone stands in it. The block brings both sensor levels into the clock domain and runs a small watcher per doorway. Each watcher turns one low interval into a single count request, however long the interval lasts. A shared up/down counter adds arrivals and removes departures.

The running total leaves the block in three forms. The first is plain binary. The second is packed decimal digits. The third is one segment pattern per decimal digit, ready for a display driver. The counter saturates at both ends and never wraps. A departure that lands in the same cycle as an arrival cancels it. Sensor debouncing and the physical display drive sit outside the block.

Top module: `room_occupancy_counter`

## Requirements
- R1: While `rst_n` is low the count is 0, both doorway watchers are ready to detect a new passage, and the synchronizer stages hold the idle level 1. The reset takes effect without waiting for a clock edge.
- R2: Each low interval on `entry_beam_n` raises the count by exactly one, whether the interval lasts one cycle or many.
- R3: Each low interval on `exit_beam_n` lowers the count by exactly one, whether the interval lasts one cycle or many.
- R4: With the default two synchronizer stages, the count changes on the third rising clock edge after the sensor input goes low. Before that edge it keeps its old value.
- R5: If an arrival request and a departure request reach the counter in the same cycle, the count keeps its value.
- R6: An arrival while the count is 255 (all ones for `COUNT_W` = 8) leaves the count at 255.
- R7: A departure while the count is 0 leaves the count at 0.
- R8: `occ_bcd` holds the count as decimal digits, four bits each: ones in bits 3:0, tens in bits 7:4, hundreds in bits 11:8.
- R9: `occ_seg` holds seven bits per decimal digit, in the same digit order as `occ_bcd`. Within each group, bit 0 is segment a through bit 6 segment g, and a 1 means lit. The digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R10: A sensor held low at one doorway does not stop passages at the other doorway from being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| entry_beam_n | input | 1 | Entry doorway sensor, 0 while the beam is blocked |
| exit_beam_n | input | 1 | Exit doorway sensor, 0 while the beam is blocked |
| occupancy | output | COUNT_W (8) | Current count in binary |
| occ_bcd | output | 4*DIGITS (12) | Count as packed decimal digits |
| occ_seg | output | 7*DIGITS (21) | Segment patterns, one group per digit |

## Verification
If a doorway watcher gets stuck in its waiting state, the next passage at that doorway is lost. The count then stays below the reference from that passage's third edge onward. A watcher that fails to wait produces a surplus of one for every cycle of a held-low interval. The fault appears at the ports one cycle after the first extra request and grows from there. Because every output is compared with the reference model on every clock, a fault in the counter or in the decimal encoding shows up in the first cycle that it touches the total.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic {
    DOOR_READY   = 1'b0,
    DOOR_BLOCKED = 1'b1
  } door_state_e;

  // Number of decimal digits needed for the largest value of a counter of the given width.
  function automatic int dec_digits(input int bits);
    longint v;
    int     n;
    v = (longint'(1) << bits) - 1;
    n = 0;
    do begin
      n++;
      v = v / 10;
    end while (v > 0);
    return n;
  endfunction

  // Segment pattern, bit 0 = a ... bit 6 = g, active high.
  function automatic logic [6:0] seg_encode(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/occ_sync.sv
module occ_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '1;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/occ_door_fsm.sv
module occ_door_fsm
  import occ_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beam_clear,
  output logic pass_pulse
);

  door_state_e state_q;
  door_state_e state_d;

  always_comb begin
    state_d    = state_q;
    pass_pulse = 1'b0;
    case (state_q)
      DOOR_READY: begin
        if (!beam_clear) begin
          pass_pulse = 1'b1;
          state_d    = DOOR_BLOCKED;
        end
      end
      DOOR_BLOCKED: begin
        if (beam_clear) state_d = DOOR_READY;
      end
      default: state_d = DOOR_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DOOR_READY;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/occ_updown.sv
module occ_updown #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               dec,
  output logic [COUNT_W-1:0] count
);

  localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] count_q;
  logic [COUNT_W-1:0] count_d;
  logic               up_ok;
  logic               down_ok;
  logic               load_en;

  always_comb begin
    up_ok   = inc && !dec && (count_q != MAXV);
    down_ok = dec && !inc && (count_q != '0);
    load_en = up_ok || down_ok;
    count_d = count_q;
    if (up_ok)        count_d = count_q + COUNT_W'(1);
    else if (down_ok) count_d = count_q - COUNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (load_en) count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/occ_bin2bcd.sv
module occ_bin2bcd #(
  parameter int BIN_W  = 8,
  parameter int DIGITS = 3
) (
  input  logic [BIN_W-1:0]    bin,
  output logic [4*DIGITS-1:0] bcd
);

  localparam int TOT_W = BIN_W + 4 * DIGITS;

  logic [TOT_W-1:0] work;

  always_comb begin
    work = '0;
    work[BIN_W-1:0] = bin;
    for (int i = 0; i < BIN_W; i++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (work[BIN_W + 4*d +: 4] >= 4'd5)
          work[BIN_W + 4*d +: 4] = work[BIN_W + 4*d +: 4] + 4'd3;
      end
      work = work << 1;
    end
    bcd = work[BIN_W +: 4*DIGITS];
  end

endmodule

// File: rtl/room_occupancy_counter.sv
module room_occupancy_counter
  import occ_pkg::*;
#(
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIGITS      = occ_pkg::dec_digits(COUNT_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 entry_beam_n,
  input  logic                 exit_beam_n,
  output logic [COUNT_W-1:0]   occupancy,
  output logic [4*DIGITS-1:0]  occ_bcd,
  output logic [7*DIGITS-1:0]  occ_seg
);

  localparam int DOORS = 2;

  logic [DOORS-1:0] beam_sync;
  logic [DOORS-1:0] door_pulse;
  logic             entry_pulse;
  logic             exit_pulse;

  occ_sync #(
    .WIDTH  (DOORS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({exit_beam_n, entry_beam_n}),
    .q     (beam_sync)
  );

  generate
    for (genvar g = 0; g < DOORS; g++) begin : g_door
      occ_door_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .beam_clear (beam_sync[g]),
        .pass_pulse (door_pulse[g])
      );
    end
  endgenerate

  assign entry_pulse = door_pulse[0];
  assign exit_pulse  = door_pulse[1];

  occ_updown #(
    .COUNT_W (COUNT_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (entry_pulse),
    .dec   (exit_pulse),
    .count (occupancy)
  );

  occ_bin2bcd #(
    .BIN_W  (COUNT_W),
    .DIGITS (DIGITS)
  ) u_bcd (
    .bin (occupancy),
    .bcd (occ_bcd)
  );

  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_seg
      assign occ_seg[7*k +: 7] = seg_encode(occ_bcd[4*k +: 4]);
    end
  endgenerate

endmodule

// File: rtl/occ_checker.sv
module occ_checker #(
  parameter int COUNT_W = 8,
  parameter int DIGITS  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [COUNT_W-1:0]  occupancy,
  input logic [4*DIGITS-1:0] occ_bcd,
  input logic                entry_pulse,
  input logic                exit_pulse
);

  localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

  // R2 R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occupancy == $past(occupancy)) ||
             (occupancy == $past(occupancy) + COUNT_W'(1)) ||
             (occupancy == $past(occupancy) - COUNT_W'(1)));

  // R2
  entry_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |=> !entry_pulse);

  // R3
  exit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

  // R5
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && exit_pulse) |=> $stable(occupancy));

  // R6
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == MAXV) |=> (occupancy != '0));

  // R7
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |=> (occupancy != MAXV));

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      // R8
      digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_bcd[4*d +: 4] <= 4'd9);
    end
  endgenerate

endmodule

bind room_occupancy_counter occ_checker #(
  .COUNT_W (COUNT_W),
  .DIGITS  (DIGITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .occupancy   (occupancy),
  .occ_bcd     (occ_bcd),
  .entry_pulse (entry_pulse),
  .exit_pulse  (exit_pulse)
);

// File: tb/room_occupancy_counter_tb.sv
module room_occupancy_counter_tb;

  localparam int CW = 8;
  localparam int DG = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          entry_n;
  logic          exit_n;
  logic [CW-1:0] occupancy;
  logic [4*DG-1:0] occ_bcd;
  logic [7*DG-1:0] occ_seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_count = 0;
  bit m_e1 = 1, m_e2 = 1, m_x1 = 1, m_x2 = 1;
  bit m_earm = 1, m_xarm = 1;
  bit m_ep, m_xp;

  always #5 clk = ~clk;

  room_occupancy_counter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .entry_beam_n (entry_n),
    .exit_beam_n  (exit_n),
    .occupancy    (occupancy),
    .occ_bcd      (occ_bcd),
    .occ_seg      (occ_seg)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int seg_ref(input int dig);
    int lut [10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
    return lut[dig];
  endfunction

  function automatic int bcd_ref(input int v);
    return (v / 100) * 256 + ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  function automatic int seg_all_ref(input int v);
    return (seg_ref(v / 100) << 14) | (seg_ref((v / 10) % 10) << 7) | seg_ref(v % 10);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0;
      m_e1 = 1; m_e2 = 1; m_x1 = 1; m_x2 = 1;
      m_earm = 1; m_xarm = 1;
    end else begin
      m_ep = m_earm && !m_e2;
      m_xp = m_xarm && !m_x2;
      if (m_ep && !m_xp && m_count < 255) m_count = m_count + 1;
      else if (m_xp && !m_ep && m_count > 0) m_count = m_count - 1;
      if (m_earm && !m_e2) m_earm = 0; else if (!m_earm && m_e2) m_earm = 1;
      if (m_xarm && !m_x2) m_xarm = 0; else if (!m_xarm && m_x2) m_xarm = 1;
      m_e2 = m_e1; m_e1 = entry_n;
      m_x2 = m_x1; m_x1 = exit_n;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check("R2/R3/R4 occupancy", int'(occupancy), m_count);
      check("R8 bcd", int'(occ_bcd), bcd_ref(m_count));
      check("R9 seg", int'(occ_seg), seg_all_ref(m_count));
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pass_entry(input int low_cyc, input int gap_cyc);
    entry_n = 1'b0;
    wait_neg(low_cyc);
    entry_n = 1'b1;
    wait_neg(gap_cyc);
  endtask

  task automatic pass_exit(input int low_cyc, input int gap_cyc);
    exit_n = 1'b0;
    wait_neg(low_cyc);
    exit_n = 1'b1;
    wait_neg(gap_cyc);
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n   = 1'b0;
    entry_n = 1'b1;
    exit_n  = 1'b1;
    wait_neg(3);
    // R1: reset state
    check("R1 reset count", int'(occupancy), 0);
    check("R1 reset bcd", int'(occ_bcd), 0);
    check("R1 reset seg", int'(occ_seg), 'h0FDFBF);
    rst_n = 1'b1;
    wait_neg(2);

    // R4: latency of a long entry interval
    entry_n = 1'b0;
    wait_neg(1);
    check("R4 edge1 old", int'(occupancy), 0);
    wait_neg(1);
    check("R4 edge2 old", int'(occupancy), 0);
    wait_neg(1);
    check("R4 edge3 new", int'(occupancy), 1);
    wait_neg(10);
    // R2: held low counted only once
    check("R2 held low once", int'(occupancy), 1);
    entry_n = 1'b1;
    wait_neg(4);

    // R2: intervals of differing length
    pass_entry(1, 3);
    pass_entry(2, 2);
    pass_entry(5, 1);
    pass_entry(1, 1);
    wait_neg(4);
    check("R2 five entries", int'(occupancy), 5);

    // R3: exits
    pass_exit(1, 2);
    pass_exit(7, 4);
    check("R3 two exits", int'(occupancy), 3);

    // R5: simultaneous arrival and departure
    entry_n = 1'b0;
    exit_n  = 1'b0;
    wait_neg(6);
    check("R5 tie holds", int'(occupancy), 3);
    entry_n = 1'b1;
    exit_n  = 1'b1;
    wait_neg(4);

    // R10: entry held low, exits still counted
    entry_n = 1'b0;
    wait_neg(4);
    pass_exit(1, 2);
    pass_exit(3, 2);
    entry_n = 1'b1;
    wait_neg(4);
    check("R10 exits during blocked entry", int'(occupancy), 2);

    // R7: drain past zero
    for (int i = 0; i < 5; i++) pass_exit(1, 1);
    wait_neg(4);
    check("R7 floor at zero", int'(occupancy), 0);
    check("R9 seg at zero", int'(occ_seg), 'h0FDFBF);

    // R6: fill past the top
    for (int i = 0; i < 260; i++) pass_entry(1, 1);
    wait_neg(4);
    check("R6 saturate", int'(occupancy), 255);
    check("R8 bcd 255", int'(occ_bcd), 'h255);
    check("R9 seg 255", int'(occ_seg), (seg_ref(2) << 14) | (seg_ref(5) << 7) | seg_ref(5));

    // R8 R9: a mid value with a zero digit
    for (int i = 0; i < 148; i++) pass_exit(1, 1);
    wait_neg(4);
    check("R8 bcd 107", int'(occ_bcd), 'h107);
    check("R9 seg 107", int'(occ_seg), (seg_ref(1) << 14) | (seg_ref(0) << 7) | seg_ref(7));

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async clear", int'(occupancy), 0);
    check("R1 async bcd", int'(occ_bcd), 0);
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    pass_entry(2, 4);
    check("R1 R2 count after reset", int'(occupancy), 1);
    wait_neg(2);

    finish_run();
  end

  initial begin
    wait_neg(20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule